// File: doc/BRIEF.md
# PCI Target Burst Address Sequencer

This block sits on the target side of a PCI memory agent. It watches FRAME# for the start of a transaction and latches the address and command. It then decides whether to claim the access. In positive mode it claims a memory command whose address falls inside a fixed, naturally aligned window. In subtractive mode it claims a memory command only when no other agent has asserted DEVSEL# within a fixed decode delay.

The two low address bits set the burst order. Code 00 gives a linear incrementing burst. Code 10 gives a burst that wraps inside the 32-byte line holding the start address. Codes 01 and 11 are reserved, and the target completes exactly one data phase before it disconnects. A word address advances on every clock edge where both IRDY# and TRDY# are low. The line commands (read line, write and invalidate) move exactly one line, so the target asks for a disconnect on the eighth data phase.

The outputs feed the target's data path and its STOP#/DEVSEL# logic. These outputs are the claim flag, the current 30-bit word address, the burst-order code and a disconnect request that marks the current data phase as the last.

Top module: `pci_burst_seq`

## Requirements
- R1: After reset, claim and disconnect are low.
- R2: With subtractive low, a memory command whose AD[31:20] equals 0x800 is claimed. Claim is high starting with the clock after the address phase (the first edge where FRAME# is low while the sequencer is idle). An address outside that window is not claimed.
- R3: With subtractive high, a memory command at any address is claimed. Claim rises two clocks after the address-phase edge, and only if otherDevselN was high at both of the two edges after the address phase. If otherDevselN is low at either edge, the transaction is never claimed.
- R4: Only the memory commands are claimed: 0110, 0111, 1100, 1110 and 1111 on C/BE[3:0]. Reserved codes such as 0100 and 1000, and all I/O and configuration commands, are never claimed.
- R5: With AD[1:0]=00 at the address phase, wordAddr starts at AD[31:2] and increases by one after each completed data phase.
- R6: With AD[1:0]=10, wordAddr starts at AD[31:2]. After each completed data phase its low three bits advance modulo 8, and bits [29:3] stay fixed.
- R7: wordAddr changes only on an edge where both IRDY# and TRDY# are low while the transaction is claimed. A stall on either side holds it.
- R8: With AD[1:0]=01 or 11, disconnect is high for the whole claim, so the first data phase is the last one.
- R9: For commands 1110 and 1111 in order 00 or 10, disconnect goes high once seven data phases have completed, so the eighth phase ends the burst.
- R10: Claim falls on the edge that completes a data phase while FRAME# is high, or on an edge where FRAME# and IRDY# are both high.
- R11: burstMode reads 0 for linear, 1 for wrap and 2 for a reserved order code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameN | input | 1 | FRAME#, active low |
| irdyN | input | 1 | IRDY#, active low |
| trdyN | input | 1 | TRDY# of this target, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe | input | 4 | Command / byte enables |
| otherDevselN | input | 1 | Low when another agent has claimed |
| subtractive | input | 1 | 1 selects subtractive decode, 0 window decode |
| claim | output | 1 | Transaction claimed by this target |
| wordAddr | output | 30 | Word address of the current data phase |
| burstMode | output | 2 | Burst order code (0 linear, 1 wrap, 2 single) |
| disconnect | output | 1 | Current data phase must be the last |

## Verification
The hardest case to reach is a subtractive decode where another agent claims on the last edge of the decode window. In that case claim must never rise, although one more clock would have let it rise. Each transaction schedules when otherDevselN falls, relative to the address phase, so the stimulus can hit the first edge, the second edge, or just after the window. Wrap bursts that start at the last word of a line, and line commands asked for more than eight phases, drive the address and disconnect paths across their boundaries. Random IRDY#/TRDY# stalls are compared cycle by cycle against a behavioural model.

// File: rtl/pciseq_pkg.sv
package pciseq_pkg;

  typedef enum logic [1:0] {
    BM_LINEAR = 2'd0,
    BM_WRAP   = 2'd1,
    BM_SINGLE = 2'd2
  } burstMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic advance;
  } seqStrobe_t;

  // decode results from datapath to control
  typedef struct packed {
    logic       liveMem;
    logic       liveHit;
    logic       heldMem;
    logic       heldLine;
    burstMode_e heldMode;
  } decodeInfo_t;

  localparam logic [3:0] CMD_MEM_READ   = 4'b0110;
  localparam logic [3:0] CMD_MEM_WRITE  = 4'b0111;
  localparam logic [3:0] CMD_READ_MULTI = 4'b1100;
  localparam logic [3:0] CMD_READ_LINE  = 4'b1110;
  localparam logic [3:0] CMD_WRITE_INV  = 4'b1111;

  function automatic logic isMemCmd(input logic [3:0] c);
    return (c == CMD_MEM_READ) || (c == CMD_MEM_WRITE) || (c == CMD_READ_MULTI) ||
           (c == CMD_READ_LINE) || (c == CMD_WRITE_INV);
  endfunction

  function automatic logic isLineCmd(input logic [3:0] c);
    return (c == CMD_READ_LINE) || (c == CMD_WRITE_INV);
  endfunction

  function automatic burstMode_e orderOf(input logic [1:0] lowBits);
    burstMode_e m;
    case (lowBits)
      2'b00:   m = BM_LINEAR;
      2'b10:   m = BM_WRAP;
      default: m = BM_SINGLE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pciseq_datapath.sv
module pciseq_datapath
  import pciseq_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                WIN_BITS   = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
  parameter int                LINE_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ad,
  input  logic [3:0]        cbe,
  input  seqStrobe_t        strobe,
  output decodeInfo_t       decode,
  output logic [ADDR_W-3:0] wordAddr
);

  localparam int WORD_W = ADDR_W - 2;
  localparam int IDX_W  = $clog2(LINE_WORDS);

  logic [WORD_W-1:0] addrReg;
  logic [3:0]        cmdReg;
  burstMode_e        modeReg;
  logic              liveHit;

  generate
    if (WIN_BITS >= ADDR_W) begin : g_fullSpace
      assign liveHit = 1'b1;
    end else begin : g_window
      assign liveHit = (ad[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      cmdReg  <= '0;
      modeReg <= BM_LINEAR;
    end else if (strobe.capture) begin
      addrReg <= ad[ADDR_W-1:2];
      cmdReg  <= cbe;
      modeReg <= orderOf(ad[1:0]);
    end else if (strobe.advance) begin
      if (modeReg == BM_WRAP)
        addrReg <= {addrReg[WORD_W-1:IDX_W], addrReg[IDX_W-1:0] + IDX_W'(1)};
      else
        addrReg <= addrReg + WORD_W'(1);
    end
  end

  always_comb begin
    decode.liveMem  = isMemCmd(cbe);
    decode.liveHit  = liveHit;
    decode.heldMem  = isMemCmd(cmdReg);
    decode.heldLine = isLineCmd(cmdReg);
    decode.heldMode = modeReg;
  end

  assign wordAddr = addrReg;

  // R5: linear and single orders step the whole word address by one
  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.capture && modeReg != BM_WRAP) |=>
      (wordAddr == $past(wordAddr) + WORD_W'(1)));

  // R6: wrap order keeps the line and steps the index modulo the line
  a_r6_wrap_in_line: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !strobe.capture && modeReg == BM_WRAP) |=>
      ((wordAddr[WORD_W-1:IDX_W] == $past(wordAddr[WORD_W-1:IDX_W])) &&
       (wordAddr[IDX_W-1:0] == $past(wordAddr[IDX_W-1:0]) + IDX_W'(1))));

  // R7: without a strobe the address holds
  a_r7_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.capture) |=> $stable(wordAddr));

endmodule

// File: rtl/pciseq_ctrl.sv
module pciseq_ctrl
  import pciseq_pkg::*;
#(
  parameter int SUB_DELAY  = 2,
  parameter int LINE_WORDS = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameN,
  input  logic        irdyN,
  input  logic        trdyN,
  input  logic        otherDevselN,
  input  logic        subtractive,
  input  decodeInfo_t decode,
  output seqStrobe_t  strobe,
  output logic        claim,
  output logic        disconnect
);

  localparam int DLY_W   = (SUB_DELAY > 1) ? $clog2(SUB_DELAY) : 1;
  localparam int PHASE_W = $clog2(LINE_WORDS) + 1;
  localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(LINE_WORDS - 1);
  localparam logic [DLY_W-1:0]   DLY_END    = DLY_W'(SUB_DELAY - 1);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_DATA   = 2'd2,
    ST_WAIT   = 2'd3
  } seqState_e;

  seqState_e         state, stateNext;
  logic [DLY_W-1:0]   dlyCnt;
  logic [PHASE_W-1:0] phases;
  logic               busIdle;
  logic               phaseDone;

  assign busIdle   = frameN && irdyN;
  assign phaseDone = (state == ST_DATA) && !irdyN && !trdyN;

  always_comb begin
    strobe.capture = (state == ST_IDLE) && !frameN;
    strobe.advance = phaseDone;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (!frameN) begin
          if (!decode.liveMem)  stateNext = ST_WAIT;
          else if (subtractive) stateNext = ST_DECODE;
          else if (decode.liveHit) stateNext = ST_DATA;
          else                  stateNext = ST_WAIT;
        end
      end
      ST_DECODE: begin
        if (busIdle)                stateNext = ST_IDLE;
        else if (!otherDevselN)     stateNext = ST_WAIT;
        else if (dlyCnt == DLY_END) stateNext = ST_DATA;
      end
      ST_DATA: begin
        if (phaseDone && frameN) stateNext = ST_IDLE;
        else if (busIdle)        stateNext = ST_IDLE;
      end
      default: begin
        if (busIdle) stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      dlyCnt <= '0;
      phases <= '0;
    end else begin
      state <= stateNext;
      if (strobe.capture) begin
        dlyCnt <= '0;
        phases <= '0;
      end else begin
        if (state == ST_DECODE && dlyCnt != DLY_END)
          dlyCnt <= dlyCnt + DLY_W'(1);
        if (phaseDone && phases != LAST_PHASE)
          phases <= phases + PHASE_W'(1);
      end
    end
  end

  assign claim      = (state == ST_DATA);
  assign disconnect = claim &&
                      ((decode.heldMode == BM_SINGLE) ||
                       (decode.heldLine && phases == LAST_PHASE));

  // R3: another agent's DEVSEL# during the decode window blocks the claim
  a_r3_sub_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECODE && !otherDevselN) |=> !claim);

  // R4: only memory commands are ever claimed
  a_r4_claim_memory: assert property (@(posedge clk) disable iff (!rstN)
    claim |-> decode.heldMem);

  // R2: window decode claims on the clock after the address phase
  a_r2_claim_timing: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(claim) && !$past(subtractive)) |-> $past(strobe.capture));

  // R10: a completed phase with FRAME# high releases the claim
  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    (claim && !irdyN && !trdyN && frameN) |=> !claim);

endmodule

// File: rtl/pci_burst_seq.sv
module pci_burst_seq
  import pciseq_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                WIN_BITS   = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h8000_0000,
  parameter int                LINE_WORDS = 8,
  parameter int                SUB_DELAY  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic              irdyN,
  input  logic              trdyN,
  input  logic [ADDR_W-1:0] ad,
  input  logic [3:0]        cbe,
  input  logic              otherDevselN,
  input  logic              subtractive,
  output logic              claim,
  output logic [ADDR_W-3:0] wordAddr,
  output logic [1:0]        burstMode,
  output logic              disconnect
);

  seqStrobe_t  strobe;
  decodeInfo_t decode;

  pciseq_ctrl #(
    .SUB_DELAY (SUB_DELAY),
    .LINE_WORDS(LINE_WORDS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameN      (frameN),
    .irdyN       (irdyN),
    .trdyN       (trdyN),
    .otherDevselN(otherDevselN),
    .subtractive (subtractive),
    .decode      (decode),
    .strobe      (strobe),
    .claim       (claim),
    .disconnect  (disconnect)
  );

  pciseq_datapath #(
    .ADDR_W    (ADDR_W),
    .WIN_BITS  (WIN_BITS),
    .WIN_BASE  (WIN_BASE),
    .LINE_WORDS(LINE_WORDS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ad      (ad),
    .cbe     (cbe),
    .strobe  (strobe),
    .decode  (decode),
    .wordAddr(wordAddr)
  );

  assign burstMode = decode.heldMode;

endmodule

// File: tb/pci_burst_seq_test.sv
module pci_burst_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1, irdyN = 1'b1, trdyN = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe = '0;
  logic        otherDevselN = 1'b1;
  logic        subtractive = 1'b0;
  logic        claim;
  logic [29:0] wordAddr;
  logic [1:0]  burstMode;
  logic        disconnect;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_burst_seq uut (
    .clk(clk), .rstN(rstN), .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN),
    .ad(ad), .cbe(cbe), .otherDevselN(otherDevselN), .subtractive(subtractive),
    .claim(claim), .wordAddr(wordAddr), .burstMode(burstMode), .disconnect(disconnect)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          mState;   // 0 idle, 1 decoding, 2 claimed, 3 ignoring
  logic [29:0] mAddr;
  logic [1:0]  mLow;
  logic [3:0]  mCmd;
  int          mPh, mDly;
  logic        mSub;

  function automatic bit memCmd(input logic [3:0] c);
    int good[$] = '{6, 7, 12, 14, 15};
    foreach (good[i]) if (int'(c) == good[i]) return 1'b1;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0; mAddr = '0; mLow = '0; mCmd = '0; mPh = 0; mDly = 0; mSub = 0;
    end else begin
      case (mState)
        0: if (!frameN) begin
          mAddr = ad[31:2]; mLow = ad[1:0]; mCmd = cbe; mPh = 0; mDly = 0; mSub = subtractive;
          if (!memCmd(cbe)) mState = 3;
          else if (subtractive) mState = 1;
          else if (ad[31:20] == 12'h800) mState = 2;
          else mState = 3;
        end
        1: begin
          if (frameN && irdyN) mState = 0;
          else if (!otherDevselN) mState = 3;
          else begin mDly++; if (mDly == 2) mState = 2; end
        end
        2: begin
          if (!irdyN && !trdyN) begin
            mPh++;
            if (mLow == 2'b10) mAddr = {mAddr[29:3], mAddr[2:0] + 3'd1};
            else mAddr = mAddr + 30'd1;
            if (frameN) mState = 0;
          end else if (frameN && irdyN) mState = 0;
        end
        default: if (frameN && irdyN) mState = 0;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic expClaim, expDisc;
      logic [1:0] expMode;
      string cTag, aTag, dTag;
      expClaim = (mState == 2);
      expMode  = (mLow == 2'b00) ? 2'd0 : (mLow == 2'b10) ? 2'd1 : 2'd2;
      expDisc  = expClaim && (mLow[0] || ((mCmd == 4'hE || mCmd == 4'hF) && mPh >= 7));
      cTag = !memCmd(mCmd) ? "R4" : (mSub ? "R3" : "R2");
      aTag = (mLow == 2'b10) ? "R6" : "R5";
      dTag = mLow[0] ? "R8" : "R9";
      chk(cTag, {31'd0, claim}, {31'd0, expClaim});
      chk(dTag, {31'd0, disconnect}, {31'd0, expDisc});
      if (expClaim) begin
        chk(aTag, {2'd0, wordAddr}, {2'd0, mAddr});
        chk("R11", {30'd0, burstMode}, {30'd0, expMode});
      end
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idleBus(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      frameN = 1; irdyN = 1; trdyN = 1; otherDevselN = 1; ad = '0; cbe = '0;
    end
  endtask

  // one master transaction; otherAt = 0 means no other agent claims
  task automatic runTxn(input logic [31:0] addr, input logic [3:0] cmd, input int nPh,
                        input bit sub, input int otherAt, input bit stall, output bit sawClaim);
    int remaining, cyc;
    bit lastSent, irdyGo, trdyGo;
    sawClaim = 0;
    @(negedge clk);
    subtractive = sub; frameN = 0; ad = addr; cbe = cmd; irdyN = 1; trdyN = 1; otherDevselN = 1;
    remaining = nPh; cyc = 0; lastSent = 0;
    while (remaining > 0) begin
      @(negedge clk);
      cyc++;
      if (claim) sawClaim = 1;
      if (!sawClaim && cyc > 5) break;
      ad = 32'hD000_0000 + cyc; cbe = 4'h0;
      otherDevselN = !(otherAt != 0 && cyc >= otherAt);
      irdyGo = lastSent || !stall || (cyc % 3 != 0);
      trdyGo = claim && (!stall || (cyc % 4 != 1));
      if (irdyGo && (remaining == 1 || (disconnect && trdyGo))) lastSent = 1;
      irdyN = !irdyGo; trdyN = !trdyGo; frameN = lastSent;
      if (irdyGo && trdyGo) begin
        remaining--;
        if (lastSent) remaining = 0;
      end
    end
    idleBus(1);
    chk("R10", {31'd0, claim}, 32'd0);
    idleBus(1);
  endtask

  initial begin
    bit got;
    logic [3:0] cmdList[8] = '{4'h6, 4'h7, 4'hC, 4'hE, 4'hF, 4'h4, 4'h2, 4'hA};
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", {31'd0, claim}, 32'd0);
    chk("R1", {31'd0, disconnect}, 32'd0);

    runTxn(32'h8000_0100, 4'h6, 6, 0, 0, 0, got); chk("R2", {31'd0, got}, 32'd1);
    runTxn(32'h800F_FFF0, 4'h7, 5, 0, 0, 1, got); chk("R5", {31'd0, got}, 32'd1);
    runTxn(32'h9000_0000, 4'h6, 3, 0, 0, 0, got); chk("R2", {31'd0, got}, 32'd0);
    runTxn(32'h8000_001E, 4'hC, 5, 0, 0, 1, got); chk("R6", {31'd0, got}, 32'd1);
    runTxn(32'h8000_0041, 4'h6, 4, 0, 0, 0, got); chk("R8", {31'd0, got}, 32'd1);
    runTxn(32'h8000_0043, 4'h7, 4, 0, 0, 1, got); chk("R8", {31'd0, got}, 32'd1);
    runTxn(32'h8000_0200, 4'hE, 12, 0, 0, 0, got); chk("R9", {31'd0, got}, 32'd1);
    runTxn(32'h8000_0216, 4'hF, 10, 0, 0, 1, got); chk("R9", {31'd0, got}, 32'd1);
    runTxn(32'h8000_0300, 4'h4, 2, 0, 0, 0, got); chk("R4", {31'd0, got}, 32'd0);
    runTxn(32'h8000_0300, 4'h8, 2, 0, 0, 0, got); chk("R4", {31'd0, got}, 32'd0);
    runTxn(32'h8000_0300, 4'h2, 2, 1, 0, 0, got); chk("R4", {31'd0, got}, 32'd0);
    runTxn(32'h1234_5670, 4'h6, 4, 1, 0, 0, got); chk("R3", {31'd0, got}, 32'd1);
    runTxn(32'h1234_5670, 4'h6, 4, 1, 1, 0, got); chk("R3", {31'd0, got}, 32'd0);
    runTxn(32'h1234_5670, 4'h6, 4, 1, 2, 0, got); chk("R3", {31'd0, got}, 32'd0);
    runTxn(32'h2000_003E, 4'hC, 6, 1, 3, 1, got); chk("R3", {31'd0, got}, 32'd1);

    // R7: stalls on either side hold the address
    @(negedge clk);
    subtractive = 0; frameN = 0; ad = 32'h8000_0300; cbe = 4'h6;
    for (int i = 0; i < 3; i++) begin @(negedge clk); ad = 32'h0; irdyN = 1; trdyN = 0; end
    for (int i = 0; i < 2; i++) begin @(negedge clk); irdyN = 0; trdyN = 1; end
    @(negedge clk);
    chk("R7", {2'd0, wordAddr}, {2'd0, 30'h2000_00C0});
    irdyN = 0; trdyN = 0; frameN = 1;
    idleBus(1);
    chk("R10", {31'd0, claim}, 32'd0);
    idleBus(1);

    for (int n = 0; n < 60; n++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom % 3 != 0) a[31:20] = 12'h800;
      runTxn(a, cmdList[$urandom % 8], 1 + ($urandom % 11), bit'($urandom % 2),
             ($urandom % 4 == 0) ? 1 + int'($urandom % 3) : 0, bit'($urandom % 2), got);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule